// File: doc/BRIEF.md
# In-Place Exchange Sort Engine

This block keeps a small set of unsigned words in an internal register file and, on request, rearranges them into ascending order without any extra storage. While the engine is idle, the host fills the register file through a write port. It then raises a start level and waits for a completion flag. After that it reads the ordered words back through a combinational read port that uses the same address bus.

A finite-state machine drives a small datapath. The datapath holds an outer index, an inner index, two operand registers, an unsigned comparator and one write path into the register file. The outer index walks from the first word to the second-to-last. For each outer position, the inner index walks over every later word. The current minimum candidate is held in the first operand register. Whenever a later word is strictly smaller, the two words trade places, one write per cycle, and the candidate is reloaded from the outer position.

Completion is a level handshake. The flag stays up for as long as start stays high. The engine returns to waiting only after start has been seen low.

Top module: `xsort_engine`

## Requirements
- R1: A synchronous active-high reset drives `done` to 0 and puts the engine in the waiting state. It leaves the register file contents unchanged.
- R2: In the waiting state with `start` at 0, the engine does nothing: `done` stays 0 and the stored words keep their values.
- R3: A sort leaves the NUM_WORDS words at addresses 0 to NUM_WORDS-1 in ascending order, using an unsigned compare. For example, 3,2,4,1 becomes 1,2,3,4, and 0xFF is placed after 0x80.
- R4: The result is a permutation of the loaded words, duplicates included. Two words of equal value are never exchanged.
- R5: `done` rises when the sort finishes and stays at 1 while `start` remains 1. It falls on the clock edge that samples `start` at 0, and a new sort then needs `start` at 1 again.
- R6: While a sort runs, `wr_en` has no effect on the register file and `dout` reads 0. Outside a sort, `dout` shows the word at `addr`.
- R7: The outer index takes the values 0 to NUM_WORDS-2 and the inner index takes the values from outer+1 to NUM_WORDS-1. An exchange takes three steps in order: write the smaller word at the outer index, then write the larger word at the inner index, then reload the candidate.
- R8: Let the posedge that samples `start` at 1 in the waiting state count as 1. Then `done` is first 1 after exactly NUM_WORDS + NUM_WORDS*(NUM_WORDS-1) + 3*S posedges, where S is the number of exchanges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start level for the sort |
| wr_en | input | 1 | Host write enable, honoured only when no sort is running |
| addr | input | IDX_W | Host address for both reads and writes |
| din | input | WORD_W | Host write data |
| dout | output | WORD_W | Word at `addr`, or 0 while a sort runs |
| done | output | 1 | Sort complete, held until `start` falls |

## Verification
Some behaviour is checked by the assertions on every cycle. These cover the controller's handshake: it holds in waiting without start, holds in done with start, and re-arms once start drops. They also cover the fixed three-step order of an exchange, the index ranges, and the rule that an exchange write only happens when the candidate is strictly greater. Other behaviour only the bench scenarios can show. These are the ascending and permutation properties of the final contents, that memory survives reset, that host writes issued mid-sort are discarded, and the exact cycle count. That count is where swapping equal words would show up, because each exchange costs three extra cycles.

// File: rtl/xsort_pkg.sv
package xsort_pkg;

   typedef enum logic [2:0] {
      XS_WAIT,
      XS_LOAD_A,
      XS_LOAD_B,
      XS_COMPARE,
      XS_WRITE_I,
      XS_WRITE_J,
      XS_RELOAD_A,
      XS_DONE
   } xs_state_e;

endpackage

// File: rtl/xsort_regfile.sv
module xsort_regfile #(
   parameter int NUM_WORDS = 4,
   parameter int WORD_W    = 8,
   parameter int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ra_a,
   output logic [WORD_W-1:0] rd_a,
   input  logic [IDX_W-1:0]  ra_b,
   output logic [WORD_W-1:0] rd_b,
   input  logic [IDX_W-1:0]  ra_c,
   output logic [WORD_W-1:0] rd_c
);

   logic [WORD_W-1:0] words [NUM_WORDS];

   // one storage register per word, no reset so contents survive rst
   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (we && (waddr == IDX_W'(g))) q <= wdata;
      end
      assign words[g] = q;
   end

   function automatic logic [WORD_W-1:0] pick(input logic [IDX_W-1:0] ra);
      logic [WORD_W-1:0] r;
      r = '0;
      for (int n = 0; n < NUM_WORDS; n++) begin
         if (ra == IDX_W'(n)) r = words[n];
      end
      return r;
   endfunction

   assign rd_a = pick(ra_a);
   assign rd_b = pick(ra_b);
   assign rd_c = pick(ra_c);

endmodule

// File: rtl/xsort_datapath.sv
module xsort_datapath #(
   parameter int NUM_WORDS = 4,
   parameter int WORD_W    = 8,
   parameter int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr_i,
   input  logic              inc_i,
   input  logic              set_j,
   input  logic              inc_j,
   input  logic              ld_a,
   input  logic              ld_b,
   input  logic              wr_i,
   input  logic              wr_j,
   input  logic [WORD_W-1:0] rd_i_word,
   input  logic [WORD_W-1:0] rd_j_word,
   output logic [IDX_W-1:0]  i_idx,
   output logic [IDX_W-1:0]  j_idx,
   output logic              a_gt_b,
   output logic              i_last,
   output logic              j_last,
   output logic              int_we,
   output logic [IDX_W-1:0]  int_waddr,
   output logic [WORD_W-1:0] int_wdata
);

   localparam logic [IDX_W-1:0] I_END = IDX_W'(NUM_WORDS - 2);
   localparam logic [IDX_W-1:0] J_END = IDX_W'(NUM_WORDS - 1);

   logic [IDX_W-1:0]  i_q, j_q;
   logic [WORD_W-1:0] a_q, b_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         i_q <= '0;
         j_q <= '0;
      end else begin
         if (clr_i)      i_q <= '0;
         else if (inc_i) i_q <= i_q + 1'b1;
         if (set_j)      j_q <= i_q + 1'b1;
         else if (inc_j) j_q <= j_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         a_q <= '0;
         b_q <= '0;
      end else begin
         if (ld_a) a_q <= rd_i_word;
         if (ld_b) b_q <= rd_j_word;
      end
   end

   assign i_idx  = i_q;
   assign j_idx  = j_q;
   assign a_gt_b = (a_q > b_q);
   assign i_last = (i_q == I_END);
   assign j_last = (j_q == J_END);

   assign int_we    = wr_i | wr_j;
   assign int_waddr = wr_i ? i_q : j_q;
   assign int_wdata = wr_i ? b_q : a_q;

   a_r4_swap_only_greater : assert property (@(posedge clk) disable iff (rst)
      (wr_i || wr_j) |-> (a_q > b_q));

   a_r7_inner_above_outer : assert property (@(posedge clk) disable iff (rst)
      ld_b |-> ((j_q > i_q) && (j_q <= J_END)));

   a_r7_outer_range : assert property (@(posedge clk) disable iff (rst)
      ld_a |-> (i_q <= I_END));

endmodule

// File: rtl/xsort_ctrl.sv
module xsort_ctrl
   import xsort_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic a_gt_b,
   input  logic i_last,
   input  logic j_last,
   output logic clr_i,
   output logic inc_i,
   output logic set_j,
   output logic inc_j,
   output logic ld_a,
   output logic ld_b,
   output logic wr_i,
   output logic wr_j,
   output logic busy,
   output logic done
);

   xs_state_e state_q, state_d;
   logic      advance;

   always_ff @(posedge clk) begin
      if (rst) state_q <= XS_WAIT;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      clr_i   = 1'b0;
      inc_i   = 1'b0;
      set_j   = 1'b0;
      inc_j   = 1'b0;
      ld_a    = 1'b0;
      ld_b    = 1'b0;
      wr_i    = 1'b0;
      wr_j    = 1'b0;
      advance = 1'b0;
      case (state_q)
         XS_WAIT: begin
            if (start) begin
               clr_i   = 1'b1;
               state_d = XS_LOAD_A;
            end
         end
         XS_LOAD_A: begin
            ld_a    = 1'b1;
            set_j   = 1'b1;
            state_d = XS_LOAD_B;
         end
         XS_LOAD_B: begin
            ld_b    = 1'b1;
            state_d = XS_COMPARE;
         end
         XS_COMPARE: begin
            if (a_gt_b) state_d = XS_WRITE_I;
            else        advance = 1'b1;
         end
         XS_WRITE_I: begin
            wr_i    = 1'b1;
            state_d = XS_WRITE_J;
         end
         XS_WRITE_J: begin
            wr_j    = 1'b1;
            state_d = XS_RELOAD_A;
         end
         XS_RELOAD_A: begin
            ld_a    = 1'b1;
            advance = 1'b1;
         end
         XS_DONE: begin
            if (!start) state_d = XS_WAIT;
         end
         default: state_d = XS_WAIT;
      endcase

      if (advance) begin
         if (j_last) begin
            if (i_last) begin
               state_d = XS_DONE;
            end else begin
               inc_i   = 1'b1;
               state_d = XS_LOAD_A;
            end
         end else begin
            inc_j   = 1'b1;
            state_d = XS_LOAD_B;
         end
      end
   end

   assign done = (state_q == XS_DONE);
   assign busy = (state_q != XS_WAIT) && (state_q != XS_DONE);

   a_r1_reset_to_wait : assert property (@(posedge clk)
      rst |=> (state_q == XS_WAIT));

   a_r2_idle_without_start : assert property (@(posedge clk) disable iff (rst)
      ((state_q == XS_WAIT) && !start) |=> (state_q == XS_WAIT));

   a_r5_done_held : assert property (@(posedge clk) disable iff (rst)
      ((state_q == XS_DONE) && start) |=> (state_q == XS_DONE));

   a_r5_rearm : assert property (@(posedge clk) disable iff (rst)
      ((state_q == XS_DONE) && !start) |=> (state_q == XS_WAIT));

   a_r7_swap_step2 : assert property (@(posedge clk) disable iff (rst)
      (state_q == XS_WRITE_I) |=> (state_q == XS_WRITE_J));

   a_r7_swap_step3 : assert property (@(posedge clk) disable iff (rst)
      (state_q == XS_WRITE_J) |=> (state_q == XS_RELOAD_A));

endmodule

// File: rtl/xsort_engine.sv
module xsort_engine #(
   parameter int NUM_WORDS      = 4,
   parameter int WORD_W         = 8,
   parameter bit ZERO_WHEN_BUSY = 1'b1,
   localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  addr,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout,
   output logic              done
);

   if (NUM_WORDS < 2) begin : g_bad_depth
      $error("xsort_engine: NUM_WORDS must be at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("xsort_engine: WORD_W must be at least 1");
   end

   logic              clr_i, inc_i, set_j, inc_j, ld_a, ld_b, wr_i, wr_j, busy;
   logic              a_gt_b, i_last, j_last;
   logic [IDX_W-1:0]  i_idx, j_idx;
   logic              int_we;
   logic [IDX_W-1:0]  int_waddr;
   logic [WORD_W-1:0] int_wdata;
   logic              mem_we;
   logic [IDX_W-1:0]  mem_waddr;
   logic [WORD_W-1:0] mem_wdata;
   logic [WORD_W-1:0] rd_i_word, rd_j_word, rd_host;

   xsort_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .a_gt_b (a_gt_b),
      .i_last (i_last),
      .j_last (j_last),
      .clr_i  (clr_i),
      .inc_i  (inc_i),
      .set_j  (set_j),
      .inc_j  (inc_j),
      .ld_a   (ld_a),
      .ld_b   (ld_b),
      .wr_i   (wr_i),
      .wr_j   (wr_j),
      .busy   (busy),
      .done   (done)
   );

   xsort_datapath #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .IDX_W     (IDX_W)
   ) u_dp (
      .clk       (clk),
      .rst       (rst),
      .clr_i     (clr_i),
      .inc_i     (inc_i),
      .set_j     (set_j),
      .inc_j     (inc_j),
      .ld_a      (ld_a),
      .ld_b      (ld_b),
      .wr_i      (wr_i),
      .wr_j      (wr_j),
      .rd_i_word (rd_i_word),
      .rd_j_word (rd_j_word),
      .i_idx     (i_idx),
      .j_idx     (j_idx),
      .a_gt_b    (a_gt_b),
      .i_last    (i_last),
      .j_last    (j_last),
      .int_we    (int_we),
      .int_waddr (int_waddr),
      .int_wdata (int_wdata)
   );

   // single write port: the sorter owns it while busy, the host otherwise
   assign mem_we    = busy ? int_we    : wr_en;
   assign mem_waddr = busy ? int_waddr : addr;
   assign mem_wdata = busy ? int_wdata : din;

   xsort_regfile #(
      .NUM_WORDS (NUM_WORDS),
      .WORD_W    (WORD_W),
      .IDX_W     (IDX_W)
   ) u_rf (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_waddr),
      .wdata (mem_wdata),
      .ra_a  (i_idx),
      .rd_a  (rd_i_word),
      .ra_b  (j_idx),
      .rd_b  (rd_j_word),
      .ra_c  (addr),
      .rd_c  (rd_host)
   );

   if (ZERO_WHEN_BUSY) begin : g_dout_gated
      assign dout = busy ? '0 : rd_host;
   end else begin : g_dout_raw
      assign dout = rd_host;
   end

   a_r6_host_write_blocked : assert property (@(posedge clk) disable iff (rst)
      (busy && wr_en && !int_we) |-> !mem_we);

   a_r5_done_not_busy : assert property (@(posedge clk) disable iff (rst)
      done |-> !busy);

endmodule

// File: tb/sim_xsort_engine.sv
`timescale 1ns/1ps
module sim_xsort_engine;

   localparam int K = 4;
   localparam int W = 8;
   localparam int IW = 2;

   typedef logic [W-1:0] vec_t [K];

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] addr = '0;
   logic [W-1:0]  din = '0;
   logic [W-1:0]  dout;
   logic          done;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   xsort_engine #(.NUM_WORDS(K), .WORD_W(W)) u0 (
      .clk(clk), .rst(rst), .start(start), .wr_en(wr_en),
      .addr(addr), .din(din), .dout(dout), .done(done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // spec model: nested exchange with candidate reload, counts exchanges
   function automatic int ref_sort(input vec_t v, output vec_t r);
      int s;
      logic [W-1:0] a, b;
      s = 0;
      r = v;
      for (int i = 0; i <= K - 2; i++) begin
         a = r[i];
         for (int j = i + 1; j <= K - 1; j++) begin
            b = r[j];
            if (a > b) begin
               r[i] = b;
               r[j] = a;
               a = r[i];
               s++;
            end
         end
      end
      return s;
   endfunction

   task automatic wr_word(input int a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = IW'(a);
      din   = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load(input vec_t v);
      for (int n = 0; n < K; n++) wr_word(n, v[n]);
   endtask

   task automatic check_contents(input string req, input vec_t e);
      for (int n = 0; n < K; n++) begin
         @(negedge clk);
         addr = IW'(n);
         #1;
         chk(req, 32'(dout), 32'(e[n]));
      end
   endtask

   task automatic run_case(input vec_t v, input bit inject);
      vec_t r;
      int s, n, exp_n;
      s = ref_sort(v, r);
      exp_n = K + K * (K - 1) + 3 * s;
      load(v);
      @(negedge clk);
      addr  = '0;
      start = 1'b1;
      n = 0;
      while (n < 1000) begin
         @(posedge clk);
         #1;
         n++;
         if (inject && n == 2) chk("R6 dout zero during sort", 32'(dout), 32'h0);
         if (inject && n == 3) begin
            wr_en = 1'b1;
            addr  = '0;
            din   = 8'hEE;
         end
         if (inject && n == 4) wr_en = 1'b0;
         if (done) break;
      end
      chk("R8 cycles to done", 32'(n), 32'(exp_n));
      repeat (2) begin
         @(posedge clk);
         #1;
         chk("R5 done held while start high", 32'(done), 32'h1);
      end
      check_contents("R3 R4 sorted result", r);
      @(negedge clk);
      start = 1'b0;
      @(posedge clk);
      #1;
      chk("R5 done falls after start low", 32'(done), 32'h0);
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      vec_t v, r;
      int dummy;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 done low after reset", 32'(done), 32'h0);

      // R3: the canonical example
      v = '{8'd3, 8'd2, 8'd4, 8'd1};
      run_case(v, 1'b0);
      check_contents("R3 example 1,2,3,4", '{8'd1, 8'd2, 8'd3, 8'd4});

      // R2: idle without start leaves contents and done alone
      v = '{8'd9, 8'd8, 8'd7, 8'd6};
      load(v);
      repeat (10) begin
         @(posedge clk);
         #1;
         chk("R2 done stays low while idle", 32'(done), 32'h0);
      end
      check_contents("R2 contents unchanged while idle", v);

      // R1: reset keeps memory
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_contents("R1 memory survives reset", v);

      // R3 unsigned ordering
      run_case('{8'hFF, 8'h01, 8'h80, 8'h7F}, 1'b0);
      // R4 duplicates, equal words never exchanged (cycle count shows it)
      run_case('{8'd5, 8'd5, 8'd5, 8'd5}, 1'b0);
      run_case('{8'd7, 8'd3, 8'd7, 8'd3}, 1'b0);
      // R8 worst case, fully reversed
      run_case('{8'd40, 8'd30, 8'd20, 8'd10}, 1'b0);
      // R6 host write and read during sort
      run_case('{8'd12, 8'd200, 8'd0, 8'd77}, 1'b1);

      // R1: reset mid-sort clears done and returns to wait
      load('{8'd4, 8'd3, 8'd2, 8'd1});
      @(negedge clk);
      start = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst   = 1'b1;
      start = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk("R1 done low after mid-sort reset", 32'(done), 32'h0);
      repeat (3) @(posedge clk);
      #1;
      chk("R2 no restart without start", 32'(done), 32'h0);

      // random mix
      for (int t = 0; t < 25; t++) begin
         for (int n = 0; n < K; n++) v[n] = W'($urandom_range(0, (t % 3 == 0) ? 3 : 255));
         run_case(v, (t % 4) == 1);
      end
      dummy = ref_sort(v, r);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule